// File: doc/BRIEF.md
# Comparison-Based Space-Vector Sector and Dwell-Time Unit

This block turns one sample of a three-phase reference into the timing data a space-vector modulator needs for one switching period. It takes three signed phase values, an unsigned Q1.15 gain that stands for the ratio of switching period to DC-bus voltage, and the switching period in counts. It returns the active sector and three dwell times: one for the adjacent active vector with one upper switch closed, one for the adjacent active vector with two upper switches closed, and one for the zero vector.

No trigonometry and no alpha-beta transform take part. Three subtractors form the line differences a−b, b−c and c−a. The sign flags of these differences select the sector. Two four-way multiplexers then pick which difference magnitudes feed the two active-vector times. A multiply by the gain and a subtraction from the period complete the work. A strobe latches one sample. A single-cycle valid pulse marks the result.

Top module: `svm_sector_timer`

## Requirements
- R1: For strictly ordered phases the sector output is 1 for a>b>c, 2 for b>a>c, 3 for b>c>a, 4 for c>b>a, 5 for c>a>b and 6 for a>c>b.
- R2: When two or three phases are equal, the sector is the lowest-numbered of the sectors whose ordering holds with "greater or equal". Three equal phases give sector 1.
- R3: The one-switch vector time t_one is floor((max−mid) × gain / 2^15), where max and mid are the largest and middle phase values.
- R4: The two-switch vector time t_two is floor((mid−min) × gain / 2^15).
- R5: When t_one + t_two does not exceed period, t_zero = period − t_one − t_two. This includes the exact-fit case, which gives t_zero = 0.
- R6: When the scaled t_one + t_two exceeds period, t_one is limited to period, t_two becomes period − t_one, and t_zero is 0. The three times then always add up to period.
- R7: A high smp_stb at a rising edge latches ph_a, ph_b, ph_c, gain and period. out_vld is high for exactly one cycle, following the second rising edge after that latch. Strobes on consecutive cycles give results on consecutive cycles. No strobe gives no valid.
- R8: While rst is high at a rising edge, out_vld, sector and all three times are driven to 0 after that edge.
- R9: Between valid pulses, sector and the three times hold their last values, whatever the inputs do while smp_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Latches one reference sample and starts a computation |
| ph_a | input | 16 | Phase a reference, two's complement |
| ph_b | input | 16 | Phase b reference, two's complement |
| ph_c | input | 16 | Phase c reference, two's complement |
| gain | input | 16 | Period over bus voltage, unsigned Q1.15 |
| period | input | 16 | Switching period in counts |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| sector | output | 3 | Active sector, 1 to 6 (0 after reset) |
| t_one | output | 16 | Time of the active vector with one upper switch on |
| t_two | output | 16 | Time of the active vector with two upper switches on |
| t_zero | output | 16 | Time of the zero vector |

## Verification
The bench builds the block with its default widths: 16-bit phases, 16-bit Q1.15 gain, 16-bit period and 15 fractional bits. With these widths, full-scale phases of opposite sign and a gain near 2.0 drive the scaled active times well past any 16-bit period. This exercises the clamp. A gain of exactly 1.0 with small differences lands on the exact-fit boundary. Odd gains expose truncation in the fixed-point product. Ties between phases at every pairing, and the all-equal case, test the priority order of the sector decoder.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
package svm_pkg;

    typedef enum logic [2:0] {
        SEC_NONE = 3'd0,
        SEC_1    = 3'd1,
        SEC_2    = 3'd2,
        SEC_3    = 3'd3,
        SEC_4    = 3'd4,
        SEC_5    = 3'd5,
        SEC_6    = 3'd6
    } sector_e;

    // Which line difference magnitude feeds a time operand
    typedef enum logic [1:0] {
        LD_AB   = 2'd0,
        LD_BC   = 2'd1,
        LD_CA   = 2'd2,
        LD_NONE = 2'd3
    } line_sel_e;

    typedef struct packed {
        logic pos;   // difference strictly positive
        logic neg;   // difference strictly negative
    } sgn_t;

    typedef struct packed {
        line_sel_e sel_one;
        line_sel_e sel_two;
    } route_t;

    // Lowest sector whose non-strict ordering holds wins (tie rule)
    function automatic sector_e decode_sector(input sgn_t ab, input sgn_t bc, input sgn_t ca);
        if (!ab.neg && !bc.neg) return SEC_1;   // a>=b>=c
        if (!ab.pos && !ca.pos) return SEC_2;   // b>=a>=c
        if (!bc.neg && !ca.neg) return SEC_3;   // b>=c>=a
        if (!bc.pos && !ab.pos) return SEC_4;   // c>=b>=a
        if (!ca.neg && !ab.neg) return SEC_5;   // c>=a>=b
        return SEC_6;                           // a>=c>=b
    endfunction

    // max-mid feeds the one-switch vector, mid-min the two-switch vector
    function automatic route_t route_for(input sector_e s);
        route_t r;
        unique case (s)
            SEC_1:   r = '{sel_one: LD_AB, sel_two: LD_BC};
            SEC_2:   r = '{sel_one: LD_AB, sel_two: LD_CA};
            SEC_3:   r = '{sel_one: LD_BC, sel_two: LD_CA};
            SEC_4:   r = '{sel_one: LD_BC, sel_two: LD_AB};
            SEC_5:   r = '{sel_one: LD_CA, sel_two: LD_AB};
            SEC_6:   r = '{sel_one: LD_CA, sel_two: LD_BC};
            default: r = '{sel_one: LD_NONE, sel_two: LD_NONE};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/svm_line_diff.sv
`timescale 1ns/1ps
module svm_line_diff
    import svm_pkg::*;
#(
    parameter int unsigned IW = 16
) (
    input  logic signed [IW-1:0] ph_a_i,
    input  logic signed [IW-1:0] ph_b_i,
    input  logic signed [IW-1:0] ph_c_i,
    output logic [2:0][IW-1:0]   mag_o,
    output sgn_t [2:0]           sgn_o
);
    localparam int unsigned DW = IW + 1;

    logic signed [2:0][IW-1:0] lhs;
    logic signed [2:0][IW-1:0] rhs;

    assign lhs[0] = ph_a_i;  assign rhs[0] = ph_b_i;
    assign lhs[1] = ph_b_i;  assign rhs[1] = ph_c_i;
    assign lhs[2] = ph_c_i;  assign rhs[2] = ph_a_i;

    for (genvar i = 0; i < 3; i++) begin : g_line
        logic signed [DW-1:0] diff;
        logic signed [DW-1:0] diff_n;
        assign diff   = {lhs[i][IW-1], lhs[i]} - {rhs[i][IW-1], rhs[i]};
        assign diff_n = -diff;
        assign sgn_o[i].neg = diff[DW-1];
        assign sgn_o[i].pos = !diff[DW-1] && (diff != '0);
        assign mag_o[i]     = diff[DW-1] ? diff_n[IW-1:0] : diff[IW-1:0];
    end
endmodule

// File: rtl/svm_sector_stage.sv
`timescale 1ns/1ps
module svm_sector_stage
    import svm_pkg::*;
#(
    parameter int unsigned IW = 16,
    parameter int unsigned GW = 16,
    parameter int unsigned TW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [2:0][IW-1:0]   mag_i,
    input  sgn_t [2:0]           sgn_i,
    input  logic [GW-1:0]        gain_i,
    input  logic [TW-1:0]        period_i,
    output logic                 vld_o,
    output sector_e              sector_o,
    output logic [IW-1:0]        op_one_o,
    output logic [IW-1:0]        op_two_o,
    output logic [GW-1:0]        gain_o,
    output logic [TW-1:0]        period_o
);
    sector_e            sec_c;
    route_t             rt_c;
    line_sel_e [1:0]    sel_c;
    logic [1:0][IW-1:0] op_c;

    assign sec_c    = decode_sector(sgn_i[0], sgn_i[1], sgn_i[2]);
    assign rt_c     = route_for(sec_c);
    assign sel_c[0] = rt_c.sel_one;
    assign sel_c[1] = rt_c.sel_two;

    // two four-way operand multiplexers
    for (genvar k = 0; k < 2; k++) begin : g_mux
        always_comb begin
            unique case (sel_c[k])
                LD_AB:   op_c[k] = mag_i[0];
                LD_BC:   op_c[k] = mag_i[1];
                LD_CA:   op_c[k] = mag_i[2];
                default: op_c[k] = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            sector_o <= SEC_NONE;
            op_one_o <= '0;
            op_two_o <= '0;
            gain_o   <= '0;
            period_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sector_o <= sec_c;
                op_one_o <= op_c[0];
                op_two_o <= op_c[1];
                gain_o   <= gain_i;
                period_o <= period_i;
            end
        end
    end

    // R1: a computed sector is always one of the six real sectors
    a_r1_sector_legal: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (sector_o != SEC_NONE && sector_o <= SEC_6));
endmodule

// File: rtl/svm_time_scale.sv
`timescale 1ns/1ps
module svm_time_scale
    import svm_pkg::*;
#(
    parameter int unsigned MW   = 16,
    parameter int unsigned GW   = 16,
    parameter int unsigned TW   = 16,
    parameter int unsigned FRAC = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  sector_e       sector_i,
    input  logic [MW-1:0] op_one_i,
    input  logic [MW-1:0] op_two_i,
    input  logic [GW-1:0] gain_i,
    input  logic [TW-1:0] period_i,
    output logic          vld_o,
    output sector_e       sector_o,
    output logic [TW-1:0] t_one_o,
    output logic [TW-1:0] t_two_o,
    output logic [TW-1:0] t_zero_o
);
    localparam int unsigned PW = MW + GW;
    localparam int unsigned SW = PW - FRAC;
    localparam int unsigned AW = ((SW > TW) ? SW : TW) + 1;

    logic [1:0][MW-1:0] ops;
    logic [1:0][AW-1:0] scaled;
    logic [AW-1:0]      sum_c, per_c, one_c, two_c, zero_c;

    assign ops[0] = op_one_i;
    assign ops[1] = op_two_i;

    for (genvar k = 0; k < 2; k++) begin : g_scale
        logic [PW-1:0] prod;
        logic [PW-1:0] shifted;
        assign prod      = PW'(ops[k]) * PW'(gain_i);
        assign shifted   = prod >> FRAC;
        assign scaled[k] = AW'(shifted);
    end

    assign sum_c = scaled[0] + scaled[1];
    assign per_c = AW'(period_i);

    always_comb begin
        if (sum_c <= per_c) begin
            one_c  = scaled[0];
            two_c  = scaled[1];
            zero_c = per_c - sum_c;
        end else begin
            one_c  = (scaled[0] > per_c) ? per_c : scaled[0];
            two_c  = per_c - one_c;
            zero_c = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            sector_o <= SEC_NONE;
            t_one_o  <= '0;
            t_two_o  <= '0;
            t_zero_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sector_o <= sector_i;
                t_one_o  <= TW'(one_c);
                t_two_o  <= TW'(two_c);
                t_zero_o <= TW'(zero_c);
            end
        end
    end
endmodule

// File: rtl/svm_sector_timer.sv
`timescale 1ns/1ps
module svm_sector_timer
    import svm_pkg::*;
#(
    parameter int unsigned IW   = 16,
    parameter int unsigned GW   = 16,
    parameter int unsigned TW   = 16,
    parameter int unsigned FRAC = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [IW-1:0] ph_a,
    input  logic signed [IW-1:0] ph_b,
    input  logic signed [IW-1:0] ph_c,
    input  logic [GW-1:0]        gain,
    input  logic [TW-1:0]        period,
    output logic                 out_vld,
    output logic [2:0]           sector,
    output logic [TW-1:0]        t_one,
    output logic [TW-1:0]        t_two,
    output logic [TW-1:0]        t_zero
);
    localparam int unsigned XW = TW + 2;

    // sample latch
    logic                 lat_vld;
    logic signed [IW-1:0] a_q, b_q, c_q;
    logic [GW-1:0]        gain_q;
    logic [TW-1:0]        period_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_vld  <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
            c_q      <= '0;
            gain_q   <= '0;
            period_q <= '0;
        end else begin
            lat_vld <= smp_stb;
            if (smp_stb) begin
                a_q      <= ph_a;
                b_q      <= ph_b;
                c_q      <= ph_c;
                gain_q   <= gain;
                period_q <= period;
            end
        end
    end

    logic [2:0][IW-1:0] mag_w;
    sgn_t [2:0]         sgn_w;

    svm_line_diff #(.IW(IW)) u_diff (
        .ph_a_i (a_q),
        .ph_b_i (b_q),
        .ph_c_i (c_q),
        .mag_o  (mag_w),
        .sgn_o  (sgn_w)
    );

    logic          sel_vld;
    sector_e       sel_sector;
    logic [IW-1:0] sel_one, sel_two;
    logic [GW-1:0] sel_gain;
    logic [TW-1:0] sel_period;

    svm_sector_stage #(.IW(IW), .GW(GW), .TW(TW)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (lat_vld),
        .mag_i    (mag_w),
        .sgn_i    (sgn_w),
        .gain_i   (gain_q),
        .period_i (period_q),
        .vld_o    (sel_vld),
        .sector_o (sel_sector),
        .op_one_o (sel_one),
        .op_two_o (sel_two),
        .gain_o   (sel_gain),
        .period_o (sel_period)
    );

    sector_e out_sector;

    svm_time_scale #(.MW(IW), .GW(GW), .TW(TW), .FRAC(FRAC)) u_time (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (sel_vld),
        .sector_i (sel_sector),
        .op_one_i (sel_one),
        .op_two_i (sel_two),
        .gain_i   (sel_gain),
        .period_i (sel_period),
        .vld_o    (out_vld),
        .sector_o (out_sector),
        .t_one_o  (t_one),
        .t_two_o  (t_two),
        .t_zero_o (t_zero)
    );

    assign sector = out_sector;

    // R7: every strobe yields a valid pulse two cycles after its latch edge
    a_r7_strobe_to_valid: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> ##3 out_vld);

    // R7: no valid without a matching strobe
    a_r7_valid_has_strobe: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(smp_stb, 3));

    // R5/R6: the three times fill the period latched with the sample
    a_r5_times_fill_period: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (XW'(t_one) + XW'(t_two) + XW'(t_zero) == XW'($past(period, 3))));

    // R6: the one-switch time never exceeds the period
    a_r6_one_within_period: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (t_one <= $past(period, 3)));

    // R9: results hold between valid pulses
    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(t_one) && $stable(t_two) && $stable(t_zero) && $stable(sector)));
endmodule

// File: tb/svm_sector_timer_tb.sv
`timescale 1ns/1ps
module svm_sector_timer_tb;
    localparam int unsigned IW = 16;
    localparam int unsigned GW = 16;
    localparam int unsigned TW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                 rst;
    logic                 smp_stb;
    logic signed [IW-1:0] ph_a, ph_b, ph_c;
    logic [GW-1:0]        gain;
    logic [TW-1:0]        period;
    logic                 out_vld;
    logic [2:0]           sector;
    logic [TW-1:0]        t_one, t_two, t_zero;

    svm_sector_timer u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
        .gain(gain), .period(period),
        .out_vld(out_vld), .sector(sector),
        .t_one(t_one), .t_two(t_two), .t_zero(t_zero)
    );

    typedef struct {
        int    due;
        int    sec;
        longint one;
        longint two;
        longint zero;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    bit   mon_on   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(int a, int b, int c, int g, int p, int due, string tag);
        exp_t e;
        int mx, md, mn;
        longint o, t;
        if (a >= b && b >= c)      begin e.sec = 1; mx = a; md = b; mn = c; end
        else if (b >= a && a >= c) begin e.sec = 2; mx = b; md = a; mn = c; end
        else if (b >= c && c >= a) begin e.sec = 3; mx = b; md = c; mn = a; end
        else if (c >= b && b >= a) begin e.sec = 4; mx = c; md = b; mn = a; end
        else if (c >= a && a >= b) begin e.sec = 5; mx = c; md = a; mn = b; end
        else                       begin e.sec = 6; mx = a; md = c; mn = b; end
        o = (longint'(mx - md) * longint'(g)) >>> 15;
        t = (longint'(md - mn) * longint'(g)) >>> 15;
        if (o + t <= longint'(p)) begin
            e.zero = longint'(p) - o - t;
        end else begin
            if (o > longint'(p)) o = longint'(p);
            t = longint'(p) - o;
            e.zero = 0;
        end
        e.one = o; e.two = t; e.due = due; e.tag = tag;
        return e;
    endfunction

    task automatic send(int a, int b, int c, int g, int p, string tag);
        @(negedge clk);
        ph_a = IW'(a); ph_b = IW'(b); ph_c = IW'(c);
        gain = GW'(g); period = TW'(p);
        smp_stb = 1'b1;
        q.push_back(model(a, b, c, g, p, cyc + 3, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_stb = 1'b0;
            ph_a = IW'(17 * i - 900);   // inputs wander, must be ignored (R9)
            ph_b = IW'(3000 - 41 * i);
            ph_c = IW'(i * 257);
            gain = GW'(16'hFFFF - i);
            period = TW'(i + 5);
        end
    endtask

    // monitor: pops expected items and compares at the predicted cycle
    logic [2:0]    prev_sec;
    logic [TW-1:0] prev_one, prev_two, prev_zero;

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                n_checks++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R7 valid without strobe: vld=%0d expected 0", out_vld);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (cyc != e.due || int'(sector) != e.sec || longint'(t_one) != e.one ||
                        longint'(t_two) != e.two || longint'(t_zero) != e.zero) begin
                        n_fail++;
                        $display("FAIL %s cyc=%0d sec=%0d one=%0d two=%0d zero=%0d expected cyc=%0d sec=%0d one=%0d two=%0d zero=%0d",
                                 e.tag, cyc, sector, t_one, t_two, t_zero,
                                 e.due, e.sec, e.one, e.two, e.zero);
                    end
                end
            end else begin
                if (q.size() != 0 && q[0].due <= cyc) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R7 missing valid at cyc=%0d: vld=0 expected 1 (%s)", cyc, q[0].tag);
                    void'(q.pop_front());
                end
                n_checks++;
                if (sector != prev_sec || t_one != prev_one || t_two != prev_two || t_zero != prev_zero) begin
                    n_fail++;
                    $display("FAIL R9 outputs moved without valid: sec=%0d one=%0d two=%0d zero=%0d expected %0d %0d %0d %0d",
                             sector, t_one, t_two, t_zero, prev_sec, prev_one, prev_two, prev_zero);
                end
            end
        end
        prev_sec = sector; prev_one = t_one; prev_two = t_two; prev_zero = t_zero;
    end

    initial begin
        rst = 1'b1; smp_stb = 1'b0;
        ph_a = '0; ph_b = '0; ph_c = '0; gain = '0; period = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        n_checks++;
        if (out_vld !== 1'b0 || sector !== 3'd0 || t_one !== '0 || t_two !== '0 || t_zero !== '0) begin
            n_fail++;
            $display("FAIL R8 reset state: vld=%0d sec=%0d one=%0d two=%0d zero=%0d expected all 0",
                     out_vld, sector, t_one, t_two, t_zero);
        end
        rst = 1'b0;
        mon_on = 1'b1;
        idle(2);

        // R1: each strict ordering, gain 0.5
        send( 3000,  1000, -4000, 16'h4000, 20000, "R1 sector1");
        send( 1000,  3000, -4000, 16'h4000, 20000, "R1 sector2");
        send(-4000,  3000,  1000, 16'h4000, 20000, "R1 sector3");
        send(-4000,  1000,  3000, 16'h4000, 20000, "R1 sector4");
        send( 1000, -4000,  3000, 16'h4000, 20000, "R1 sector5");
        send( 3000, -4000,  1000, 16'h4000, 20000, "R1 sector6");
        idle(4);

        // R2: ties resolve to the lowest sector
        send(  500,   500,  -100, 16'h4000, 20000, "R2 tie a=b");
        idle(1);
        send(  500,  -100,  -100, 16'h4000, 20000, "R2 tie b=c");
        idle(2);
        send( -100,   500,   500, 16'h4000, 20000, "R2 tie b=c high");
        send(  500,  -100,   500, 16'h4000, 20000, "R2 tie a=c high");
        send(    7,     7,     7, 16'h4000, 20000, "R2 all equal");
        idle(4);

        // R3/R4: gain scaling and truncation
        send(12345, -6789, -30000, 16'h7FFF, 65535, "R3 R4 odd gain");
        send(  -77,   991,   -15, 16'h2AAB, 3000,  "R3 R4 small gain");
        send( 2000,  -500,  1200, 16'h0000, 4000,  "R3 R4 zero gain");
        idle(3);

        // R5: exact fit, R6: clamps
        send( 1000,   600,     0, 16'h8000, 1000,  "R5 exact fit");
        send( 1000,   600,     0, 16'h8000, 900,   "R6 two trimmed");
        send(32767,     0, -32768, 16'hFFFF, 1000, "R6 one clamped");
        send(-32768, 32767, 32767, 16'hFFFF, 65535, "R6 full scale");
        idle(3);

        // R7: long back-to-back burst
        for (int i = 0; i < 12; i++)
            send(i * 1500 - 9000, 4000 - i * 700, (i % 3) * 2000 - 2000,
                 16'h1000 + i * 16'h0C00, 5000 + i * 100, "R7 burst");
        idle(6);

        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R7 results outstanding: %0d expected 0", q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog expired: done=0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule